// File: doc/BRIEF.md
# SDRAM Controller Configuration Registers with Bank Address Decode

This block holds the software-visible configuration and status state of a four-bank SDRAM controller. It is reached through a pair of bus ports: an index port, which stores a 32-bit register selector, and a data port, which reads or writes whichever internal register that selector names. Each internal register applies its own write mask, and several carry side effects. Writing the configuration word updates status bits. Writing the ECC error status word drives an interrupt.

Each of the four bank words describes one memory window: a base address, a power-of-two size and a valid flag. The block compares an incoming physical address against every enabled window. It reports the single winning bank as a one-hot vector, and the lowest-numbered bank wins when windows overlap. The block does not sequence SDRAM commands or move data.

Top module: `sdcfg_top`

## Requirements
- R1: The index port (bus address 0x010) stores all 32 bits of a written value, returns the stored value when read, and resets to 0.
- R2: A read strobe gives `bus_rvalid` high with `bus_rdata` on the next cycle. A data-port (0x011) read returns all ones for the timing selector 0x80 and for any selector that names no register. A read at any other bus address returns 0.
- R3: Selectors 0x00 and 0x08 hold error status words that reset to 0 and are write-one-to-clear, so they stay 0. Selector 0x10 holds an error address word that stores all 32 bits and resets to 0.
- R4: The configuration word (selector 0x20) keeps only bits 31:21 of a write and resets to 0x00800000. Its bit 31 is the controller enable.
- R5: The status word (selector 0x24) resets to 0 and ignores writes. Its bit 31 is set when a configuration write clears the enable, and cleared when a write sets it. Its bit 30 is set when configuration bit 30 rises and cleared when that bit falls.
- R6: The refresh word (0x30) keeps the bits of 0x3FF80000 and resets to 0x05F00000. The ECC configuration word (0x94) keeps the bits of 0x00F00000 and resets to 0.
- R7: The power-management word (0x34) keeps write bits 31:27 and always reads with 0x07C00000 ORed in. Its reset value is 0x07C00000.
- R8: Bank words at selectors 0x40, 0x44, 0x48 and 0x4C (banks 0 to 3) keep the bits of 0xFFDEE001 and reset to 0.
- R9: A bank hits an address only when three conditions hold: its bit 0 is set, configuration bit 31 is set, and its size code (bits 19:17) is not 7. In addition, the address must match base bits 31:23 on every bit at or above log2(4 MiB << code).
- R10: `bank_hit` is one-hot or zero. Bit n stands for bank n, and the lowest-numbered matching bank wins.
- R11: The ECC error status word (0x98) keeps the bits of 0xFFF0F000 and resets to 0. `ecc_irq` is high on the cycle after any write that leaves the word nonzero, and low after any write that leaves it zero.
- R12: Writes to the status word, the timing selector or an unknown selector leave every readable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 10 | Port address: 0x010 index, 0x011 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 4 | One-hot bank hit, combinational |
| ecc_irq | output | 1 | ECC error interrupt, registered |

## Verification
A wrong stored register value shows up on `bus_rdata` on the first data-port read through its selector, one cycle after the strobe. The exception is a wrong bank word or enable bit, which changes `bank_hit` in the same cycle as the faulty state, with no read needed. A status bit that misses an enable edge stays wrong until the next configuration write, so every enable transition is followed at once by a status read. A wrong interrupt state is visible on `ecc_irq` one cycle after the ECC write that should have set or cleared it.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NBANK  = 4;

  // selector values for the data port
  localparam logic [WORD_W-1:0] SEL_ERR0   = 32'h00;
  localparam logic [WORD_W-1:0] SEL_ERR1   = 32'h08;
  localparam logic [WORD_W-1:0] SEL_ERRADR = 32'h10;
  localparam logic [WORD_W-1:0] SEL_CFG    = 32'h20;
  localparam logic [WORD_W-1:0] SEL_STAT   = 32'h24;
  localparam logic [WORD_W-1:0] SEL_RFSH   = 32'h30;
  localparam logic [WORD_W-1:0] SEL_PWR    = 32'h34;
  localparam logic [WORD_W-1:0] SEL_BANK0  = 32'h40;
  localparam logic [WORD_W-1:0] SEL_TIMING = 32'h80;
  localparam logic [WORD_W-1:0] SEL_ECCCFG = 32'h94;
  localparam logic [WORD_W-1:0] SEL_ECCERR = 32'h98;
  localparam int unsigned        BANK_STRIDE = 4;

  // write masks
  localparam logic [WORD_W-1:0] MSK_CFG    = 32'hFFE0_0000;
  localparam logic [WORD_W-1:0] MSK_RFSH   = 32'h3FF8_0000;
  localparam logic [WORD_W-1:0] MSK_PWR    = 32'hF800_0000;
  localparam logic [WORD_W-1:0] PWR_FIXED  = 32'h07C0_0000;
  localparam logic [WORD_W-1:0] MSK_BANK   = 32'hFFDE_E001;
  localparam logic [WORD_W-1:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [WORD_W-1:0] MSK_ECCERR = 32'hFFF0_F000;

  // reset values
  localparam logic [WORD_W-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [WORD_W-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [WORD_W-1:0] RST_PWR  = 32'h07C0_0000;

  // bank word fields
  localparam int unsigned BASE_LSB  = 23;
  localparam int unsigned BASE_W    = WORD_W - BASE_LSB;
  localparam int unsigned CODE_LSB  = 17;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MIN_SHIFT = 22;   // 4 MiB granule
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned SLF_BIT   = 30;
endpackage

// File: rtl/sdcfg_bank_match.sv
module sdcfg_bank_match
  import sdcfg_pkg::*;
(
  input  logic [BASE_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  input  logic              valid,
  input  logic              ctl_en,
  input  logic [WORD_W-1:0] addr,
  output logic              hit
);
  localparam logic [WORD_W-1:0] KEEP0 = ~((WORD_W'(1) << MIN_SHIFT) - WORD_W'(1));
  localparam logic [CODE_W-1:0] CODE_BAD = '1;

  logic [WORD_W-1:0] keep;
  logic [WORD_W-1:0] base_full;

  always_comb begin
    keep      = KEEP0 << code;
    base_full = {base, {BASE_LSB{1'b0}}};
    hit       = ctl_en && valid && (code != CODE_BAD) &&
                (((addr ^ base_full) & keep) == '0);
  end
endmodule

// File: rtl/sdcfg_hit_pick.sv
module sdcfg_hit_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] pick
);
  always_comb pick = raw & (~raw + N'(1));
endmodule

// File: rtl/sdcfg_rd_sel.sv
module sdcfg_rd_sel
  import sdcfg_pkg::*;
(
  input  logic [WORD_W-1:0] sel,
  input  logic [WORD_W-1:0] err0,
  input  logic [WORD_W-1:0] err1,
  input  logic [WORD_W-1:0] err_adr,
  input  logic [WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0] stat,
  input  logic [WORD_W-1:0] rfsh,
  input  logic [WORD_W-1:0] pwr,
  input  logic [WORD_W-1:0] ecc_cfg,
  input  logic [WORD_W-1:0] ecc_err,
  input  logic [NBANK-1:0][WORD_W-1:0] bank,
  output logic [WORD_W-1:0] data
);
  always_comb begin
    data = '1;
    unique case (sel)
      SEL_ERR0:   data = err0;
      SEL_ERR1:   data = err1;
      SEL_ERRADR: data = err_adr;
      SEL_CFG:    data = cfg;
      SEL_STAT:   data = stat;
      SEL_RFSH:   data = rfsh;
      SEL_PWR:    data = pwr;
      SEL_ECCCFG: data = ecc_cfg;
      SEL_ECCERR: data = ecc_err;
      default:    data = '1;
    endcase
    for (int b = 0; b < NBANK; b++)
      if (sel == SEL_BANK0 + WORD_W'(BANK_STRIDE * b)) data = bank[b];
  end
endmodule

// File: rtl/sdcfg_top.sv
module sdcfg_top
  import sdcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [9:0]  IDX_PORT  = 10'h010,
  parameter logic [9:0]  DATA_PORT = 10'h011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [WORD_W-1:0] phys_addr,
  output logic [NBANK-1:0]  bank_hit,
  output logic              ecc_irq
);
  logic [WORD_W-1:0] sel_q, err0_q, err1_q, erradr_q, cfg_q, stat_q;
  logic [WORD_W-1:0] rfsh_q, pwr_q, ecccfg_q, eccerr_q;
  logic [NBANK-1:0][WORD_W-1:0] bank_q;
  logic [WORD_W-1:0] rd_word, cfg_new, ecc_new;
  logic [NBANK-1:0]  raw_hit;
  logic wr_sel, wr_dat, cfg_wr;

  assign wr_sel  = bus_wr && (bus_addr == ADDR_W'(IDX_PORT));
  assign wr_dat  = bus_wr && (bus_addr == ADDR_W'(DATA_PORT));
  assign cfg_wr  = wr_dat && (sel_q == SEL_CFG);
  assign cfg_new = bus_wdata & MSK_CFG;
  assign ecc_new = bus_wdata & MSK_ECCERR;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      err0_q   <= '0;
      err1_q   <= '0;
      erradr_q <= '0;
      cfg_q    <= RST_CFG;
      stat_q   <= '0;
      rfsh_q   <= RST_RFSH;
      pwr_q    <= RST_PWR;
      ecccfg_q <= '0;
      eccerr_q <= '0;
      ecc_irq  <= 1'b0;
      bank_q   <= '0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata;
      if (wr_dat) begin
        unique case (sel_q)
          SEL_ERR0:   err0_q   <= err0_q & ~bus_wdata;
          SEL_ERR1:   err1_q   <= err1_q & ~bus_wdata;
          SEL_ERRADR: erradr_q <= bus_wdata;
          SEL_CFG: begin
            if (!cfg_q[EN_BIT] && cfg_new[EN_BIT])      stat_q[EN_BIT] <= 1'b0;
            else if (cfg_q[EN_BIT] && !cfg_new[EN_BIT]) stat_q[EN_BIT] <= 1'b1;
            if (!cfg_q[SLF_BIT] && cfg_new[SLF_BIT])      stat_q[SLF_BIT] <= 1'b1;
            else if (cfg_q[SLF_BIT] && !cfg_new[SLF_BIT]) stat_q[SLF_BIT] <= 1'b0;
            cfg_q <= cfg_new;
          end
          SEL_RFSH:   rfsh_q   <= bus_wdata & MSK_RFSH;
          SEL_PWR:    pwr_q    <= (bus_wdata & MSK_PWR) | PWR_FIXED;
          SEL_ECCCFG: ecccfg_q <= bus_wdata & MSK_ECCCFG;
          SEL_ECCERR: begin
            eccerr_q <= ecc_new;
            ecc_irq  <= (ecc_new != '0);
          end
          default: ;
        endcase
        for (int b = 0; b < NBANK; b++)
          if (sel_q == SEL_BANK0 + WORD_W'(BANK_STRIDE * b))
            bank_q[b] <= bus_wdata & MSK_BANK;
      end
    end
  end

  sdcfg_rd_sel u_rd_sel (
    .sel(sel_q), .err0(err0_q), .err1(err1_q), .err_adr(erradr_q),
    .cfg(cfg_q), .stat(stat_q), .rfsh(rfsh_q), .pwr(pwr_q),
    .ecc_cfg(ecccfg_q), .ecc_err(eccerr_q), .bank(bank_q), .data(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(IDX_PORT))       bus_rdata <= sel_q;
        else if (bus_addr == ADDR_W'(DATA_PORT)) bus_rdata <= rd_word;
        else                                     bus_rdata <= '0;
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdcfg_bank_match u_match (
      .base  (bank_q[g][WORD_W-1:BASE_LSB]),
      .code  (bank_q[g][CODE_LSB +: CODE_W]),
      .valid (bank_q[g][0]),
      .ctl_en(cfg_q[EN_BIT]),
      .addr  (phys_addr),
      .hit   (raw_hit[g])
    );
    AST_BANK_MASKED: assert property (@(posedge clk) disable iff (rst)
      (bank_q[g] & ~MSK_BANK) == '0); // R8
  end

  sdcfg_hit_pick #(.N(NBANK)) u_pick (.raw(raw_hit), .pick(bank_hit));

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_hit)); // R10
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[EN_BIT] |-> bank_hit == '0); // R9
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(stat_q)); // R5
  AST_PWR_FIXED: assert property (@(posedge clk) disable iff (rst)
    (pwr_q & PWR_FIXED) == PWR_FIXED); // R7
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    ecc_irq == (eccerr_q != '0)); // R11
endmodule

// File: tb/sdcfg_top_tb.sv
module sdcfg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] P_IDX = 10'h010;
  localparam logic [9:0] P_DAT = 10'h011;

  typedef struct packed {
    logic        do_wr;
    logic [7:0]  ix;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h30, 32'hFFFFFFFF, 32'h3FF80000, 8'd6},  // R6 refresh mask
    '{1'b1, 8'h94, 32'hFFFFFFFF, 32'h00F00000, 8'd6},  // R6 ECC cfg mask
    '{1'b1, 8'h34, 32'h00000000, 32'h07C00000, 8'd7},  // R7 fixed bits
    '{1'b1, 8'h34, 32'hFFFFFFFF, 32'hFFC00000, 8'd7},  // R7
    '{1'b1, 8'h20, 32'hFFFFFFFF, 32'hFFE00000, 8'd4},  // R4 config mask
    '{1'b0, 8'h24, 32'h0,        32'h40000000, 8'd5},  // R5 bit30 rose
    '{1'b1, 8'h24, 32'hFFFFFFFF, 32'h40000000, 8'd12}, // R12 status ro
    '{1'b1, 8'h20, 32'h00000000, 32'h00000000, 8'd4},  // R4
    '{1'b0, 8'h24, 32'h0,        32'h80000000, 8'd5},  // R5 enable fell
    '{1'b1, 8'h20, 32'h80000000, 32'h80000000, 8'd4},  // R4
    '{1'b0, 8'h24, 32'h0,        32'h00000000, 8'd5},  // R5 enable rose
    '{1'b1, 8'h40, 32'hFFFFFFFF, 32'hFFDEE001, 8'd8},  // R8 bank mask
    '{1'b0, 8'h80, 32'h0,        32'hFFFFFFFF, 8'd2},  // R2 timing read
    '{1'b1, 8'h80, 32'h00000000, 32'hFFFFFFFF, 8'd12}, // R12
    '{1'b1, 8'h5C, 32'h12345678, 32'hFFFFFFFF, 8'd2},  // R2 unknown sel
    '{1'b1, 8'h10, 32'hDEADBEEF, 32'hDEADBEEF, 8'd3},  // R3 err address
    '{1'b1, 8'h00, 32'hFFFFFFFF, 32'h00000000, 8'd3},  // R3 w1c
    '{1'b1, 8'h98, 32'hFFFFFFFF, 32'hFFF0F000, 8'd11}, // R11 mask
    '{1'b1, 8'h98, 32'h00000000, 32'h00000000, 8'd11}  // R11
  };

  logic clk = 1'b0, rst = 1'b1, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, phys_addr = '0, bus_rdata;
  logic        bus_rvalid, ecc_irq;
  logic [3:0]  bank_hit;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcfg_top dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .phys_addr(phys_addr), .bank_hit(bank_hit),
    .ecc_irq(ecc_irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bwr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk("R2 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic rsel(input logic [7:0] ix, output logic [31:0] d);
    bwr(P_IDX, {24'b0, ix});
    brd(P_DAT, d);
  endtask

  task automatic wsel(input logic [7:0] ix, input logic [31:0] v);
    bwr(P_IDX, {24'b0, ix});
    bwr(P_DAT, v);
  endtask

  task automatic hit_chk(input string rq, input logic [31:0] a, input logic [3:0] exp);
    @(negedge clk); phys_addr = a; #1;
    chk(rq, {28'b0, bank_hit}, {28'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R11 reset irq", {31'b0, ecc_irq}, 32'h0);
    chk("R10 reset hit", {28'b0, bank_hit}, 32'h0);
    brd(P_IDX, d);  chk("R1 reset index", d, 32'h0);
    rsel(8'h20, d); chk("R4 reset cfg", d, 32'h00800000);
    rsel(8'h24, d); chk("R5 reset status", d, 32'h0);
    rsel(8'h30, d); chk("R6 reset refresh", d, 32'h05F00000);
    rsel(8'h34, d); chk("R7 reset pwr", d, 32'h07C00000);
    rsel(8'h44, d); chk("R8 reset bank1", d, 32'h0);
    rsel(8'h08, d); chk("R3 reset err1", d, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_wr) wsel(VECS[i].ix, VECS[i].wd);
      rsel(VECS[i].ix, d);
      chk($sformatf("R%0d vec %0d", VECS[i].rq, i), d, VECS[i].ex);
    end

    // R1 index port round trip, R2 other bus address
    bwr(P_IDX, 32'hA5A5_0044);
    brd(P_IDX, d); chk("R1 index readback", d, 32'hA5A5_0044);
    brd(10'h012, d); chk("R2 other address", d, 32'h0);

    // R11 interrupt edges
    wsel(8'h98, 32'h0000_1000); chk("R11 irq rise", {31'b0, ecc_irq}, 32'h1);
    wsel(8'h98, 32'h0000_0F00); chk("R11 irq fall", {31'b0, ecc_irq}, 32'h0);

    // R9/R10 bank decode (controller enabled by table)
    wsel(8'h40, 32'h0000_0001);                       // 4 MiB at 0
    wsel(8'h44, 32'h0080_0000 | (32'd1 << 17) | 1);   // 8 MiB at 8 MiB
    wsel(8'h48, 32'h1000_0000 | (32'd6 << 17) | 1);   // 256 MiB at 256 MiB
    wsel(8'h4C, 32'h1000_0001);                       // 4 MiB at 256 MiB
    rsel(8'h4C, d); chk("R8 bank3 value", d, 32'h1000_0001);
    hit_chk("R9 bank0 inside", 32'h0010_0000, 4'b0001);
    hit_chk("R9 gap above bank0", 32'h0040_0000, 4'b0000);
    hit_chk("R9 bank1 inside", 32'h00C0_0000, 4'b0010);
    hit_chk("R10 overlap low wins", 32'h1000_0000, 4'b0100);
    hit_chk("R9 bank2 top", 32'h1FFF_FFFF, 4'b0100);
    hit_chk("R9 above all", 32'h2000_0000, 4'b0000);
    wsel(8'h48, 32'h1000_0000 | (32'd6 << 17));       // bank2 invalid
    hit_chk("R10 bank3 alone", 32'h1000_0000, 4'b1000);
    wsel(8'h40, (32'd7 << 17) | 1);                   // size code 7
    hit_chk("R9 code7 no hit", 32'h0000_0000, 4'b0000);
    wsel(8'h20, 32'h0);                               // disable
    hit_chk("R9 disabled", 32'h00C0_0000, 4'b0000);
    rsel(8'h24, d); chk("R5 status after disable", d, 32'h8000_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule